// File: doc/BRIEF.md
# Framed Packet Receiver with CRC Validation

This block takes in a serial line that rests high between transfers and rebuilds packets from it. Each packet carries a configurable number N of data frames and then one check frame. Every frame has eleven bit times: a low start bit, eight payload bits sent least significant first, an even parity bit and a high stop bit. The line passes through a two-flop synchroniser and is sampled once per clock, at eight clocks per bit. A start bit is only accepted if the line is still low at the middle of that bit. Each later bit is then sampled at its own middle.

While the data frames arrive, the receiver collects them in a shadow buffer and runs a CRC-8 over them. When the check frame arrives, the block decides on the packet as a whole. The packet is accepted only if every frame passed its parity and stop-bit checks and the check byte equals the CRC. All payload bytes then move into the output register in a single clock, with a one-cycle strobe. This lets every unit fed from that register switch in the same cycle.

A failed packet is dropped entirely and the output register keeps its old contents. A sticky flag shows which kind of failure occurred. If the line stays idle for more than two frame times, the frame count restarts, so a lost or cut-off packet cannot shift the framing of the packets after it.

Top module: `pkt_rx`

## Requirements
- R1: The line is idle high. A start bit is accepted only if the synchronised line is still low half a bit after the low level is first seen. The receiver then takes ten more samples, one bit time (8 clocks) apart. The first eight samples are the payload, least significant bit first, then the parity bit, then the stop bit.
- R2: A packet is N data frames followed by one check frame. N equals `cfg_frames`, except that 0 is treated as 1 and values above MAX_FRAMES (14) are treated as 14. `cfg_frames` is changed only between packets.
- R3: The check byte must equal a CRC-8 with polynomial 0x07 and initial value 0x00, computed most significant bit first over the payload byte values in arrival order. The result has no final inversion.
- R4: Even parity is used: the parity bit must equal the XOR of the eight payload bits. Any frame of a packet that fails this sets `err_parity`, and that packet is not applied.
- R5: A stop bit sampled low sets `err_stop`, and the packet containing that frame is not applied.
- R6: A check byte that differs from the CRC sets `err_crc`. The packet is not applied, and `payload` keeps its previous value.
- R7: When a packet is accepted, all of `payload` updates in one clock. Data frame k (from 0) lands in bits [8k+7:8k], and bytes k >= N are zero. `pkt_valid` is high for exactly that one cycle, and `payload` changes at no other time.
- R8: If the line stays idle for more than two frame times (176 clocks), the packet in progress is abandoned and the next frame is taken as data frame 0. Shorter gaps between the frames of one packet are tolerated.
- R9: After reset, `payload` is zero and `pkt_valid`, `err_parity`, `err_stop` and `err_crc` are low.
- R10: The three error flags are sticky: once set, each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 times the bit rate |
| rst_n | input | 1 | Active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| cfg_frames | input | 4 | Data frames per packet (N) |
| payload | output | 112 | Last accepted payload bytes, byte 0 in the low bits |
| pkt_valid | output | 1 | One-cycle strobe with each payload update |
| err_parity | output | 1 | Sticky parity failure flag |
| err_stop | output | 1 | Sticky stop-bit failure flag |
| err_crc | output | 1 | Sticky CRC mismatch flag |

## Verification
The hardest case to reach from the ports is a receiver whose frame count has drifted out of step with the packets. The stimulus produces it twice. First, it sends a partial packet and then a long idle. Second, it sends a frame with a low stop bit and abandons that packet halfway. In each case a clean packet must then be accepted, which shows the idle timeout realigned the framing. Random packets use random gaps between frames that stay under the timeout, so a gap that is merely long must not split a packet. Single-fault packets, one with a flipped parity bit and one with a wrong check byte, show that nothing reaches the output and that only the matching flag rises.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2
    } fr_state_e;

    // one CRC-8 step over a whole byte, MSB first, no reflection
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc_in ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_rx_sync.sv
module pkt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
    import pkt_rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s,
    output logic       fr_done,
    output logic [7:0] fr_byte,
    output logic       fr_perr,
    output logic       fr_serr,
    output logic       fr_idle
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);
    localparam logic [3:0]    LAST_BIT = 4'd9;

    typedef struct packed {
        fr_state_e       state;
        logic [CW-1:0]   cnt;
        logic [3:0]      bitn;
        logic [9:0]      shreg;
        logic            done;
        logic [7:0]      data;
        logic            perr;
        logic            serr;
    } fr_regs_t;

    fr_regs_t q, d;
    logic [9:0] sh_next;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        sh_next = {line_s, q.shreg[9:1]};
        case (q.state)
            FR_IDLE: begin
                if (!line_s) begin
                    d.state = FR_START;
                    d.cnt   = '0;
                end
            end
            FR_START: begin
                if (q.cnt == CNT_HALF) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.state = line_s ? FR_IDLE : FR_DATA;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            FR_DATA: begin
                if (q.cnt == CNT_FULL) begin
                    d.cnt   = '0;
                    d.shreg = sh_next;
                    if (q.bitn == LAST_BIT) begin
                        d.state = FR_IDLE;
                        d.done  = 1'b1;
                        d.data  = sh_next[7:0];
                        d.perr  = (^sh_next[7:0]) != sh_next[8];
                        d.serr  = !sh_next[9];
                    end else begin
                        d.bitn = q.bitn + 4'd1;
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.state = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= FR_IDLE;
        end else begin
            q <= d;
        end
    end

    assign fr_done = q.done;
    assign fr_byte = q.data;
    assign fr_perr = q.perr;
    assign fr_serr = q.serr;
    assign fr_idle = (q.state == FR_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |=> !fr_done); // R1
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FR_DATA) |-> (q.bitn <= LAST_BIT)); // R1
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |-> fr_idle); // R1
endmodule

// File: rtl/pkt_rx_idle.sv
module pkt_rx_idle #(
    parameter int LIMIT = 176
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM_M1 = TW'(LIMIT - 1);
    localparam logic [TW-1:0] LIM    = TW'(LIMIT);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          fire;
    } idle_regs_t;

    idle_regs_t q, d;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (!quiet) begin
            d.cnt = '0;
        end else if (q.cnt == LIM_M1) begin
            d.cnt  = LIM;
            d.fire = 1'b1;
        end else if (q.cnt != LIM) begin
            d.cnt = q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.fire;

    AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired); // R8
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
    import pkt_rx_pkg::*;
#(
    parameter int         MAX_FRAMES = 14,
    parameter int         OVS        = 8,
    parameter logic [7:0] CRC_POLY   = 8'h07
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_line,
    input  logic [$clog2(MAX_FRAMES+1)-1:0] cfg_frames,
    output logic [MAX_FRAMES*8-1:0]   payload,
    output logic                      pkt_valid,
    output logic                      err_parity,
    output logic                      err_stop,
    output logic                      err_crc
);
    localparam int FW         = $clog2(MAX_FRAMES + 1);
    localparam int FRAME_BITS = 11;
    localparam int IDLE_LIMIT = 2 * FRAME_BITS * OVS;
    localparam logic [FW-1:0] N_MAX = FW'(MAX_FRAMES);

    logic       line_s;
    logic       fr_done, fr_perr, fr_serr, fr_idle;
    logic [7:0] fr_byte;
    logic       timeout;
    logic [FW-1:0] n_eff;
    logic       crc_ok;

    pkt_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    pkt_rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .fr_done(fr_done), .fr_byte(fr_byte), .fr_perr(fr_perr),
        .fr_serr(fr_serr), .fr_idle(fr_idle)
    );

    pkt_rx_idle #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk(clk), .rst_n(rst_n), .quiet(fr_idle & line_s), .expired(timeout)
    );

    typedef struct packed {
        logic [FW-1:0]                 idx;
        logic [7:0]                    crc;
        logic                          bad;
        logic [MAX_FRAMES-1:0][7:0]    shadow;
        logic [MAX_FRAMES-1:0][7:0]    outreg;
        logic                          valid;
        logic                          e_par;
        logic                          e_stop;
        logic                          e_crc;
    } top_regs_t;

    top_regs_t q, d;

    always_comb begin
        if (cfg_frames == '0)        n_eff = FW'(1);
        else if (cfg_frames > N_MAX) n_eff = N_MAX;
        else                         n_eff = cfg_frames;
    end

    always_comb begin
        d      = q;
        d.valid = 1'b0;
        crc_ok = (fr_byte == q.crc);
        if (timeout) begin
            d.idx = '0;
            d.crc = '0;
            d.bad = 1'b0;
        end
        if (fr_done) begin
            if (fr_perr) d.e_par  = 1'b1;
            if (fr_serr) d.e_stop = 1'b1;
            if (q.idx < n_eff) begin
                d.shadow[q.idx] = fr_byte;
                d.crc = crc8_step(q.crc, fr_byte, CRC_POLY);
                d.bad = q.bad | fr_perr | fr_serr;
                d.idx = q.idx + FW'(1);
            end else begin
                if (!crc_ok) d.e_crc = 1'b1;
                if (crc_ok && !q.bad && !fr_perr && !fr_serr) begin
                    for (int i = 0; i < MAX_FRAMES; i++) begin
                        d.outreg[i] = (FW'(i) < n_eff) ? q.shadow[i] : 8'h00;
                    end
                    d.valid = 1'b1;
                end
                d.idx = '0;
                d.crc = '0;
                d.bad = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign payload    = q.outreg;
    assign pkt_valid  = q.valid;
    assign err_parity = q.e_par;
    assign err_stop   = q.e_stop;
    assign err_crc    = q.e_crc;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R7
    AST_PAYLOAD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (payload != $past(payload)) |-> pkt_valid); // R7
    AST_STICKY_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> err_parity); // R10
    AST_STICKY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_stop |=> err_stop); // R10
    AST_STICKY_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc |=> err_crc); // R10
    AST_NO_COMMIT_ON_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !$rose(err_crc)); // R6
    AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !fr_done) |=> (q.idx == '0)); // R8
endmodule

// File: tb/tb_pkt_rx.sv
module tb_pkt_rx;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 14;
    localparam int OVS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic [3:0] cfg_frames = 4'd14;
    logic [MAXF*8-1:0] payload;
    logic pkt_valid, err_parity, err_stop, err_crc;

    int checks = 0;
    int errors = 0;
    int valid_cnt = 0;
    int exp_cnt = 0;
    bit finished = 0;
    logic [MAXF*8-1:0] exp_pl = '0;
    logic [7:0] pl [MAXF];

    pkt_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_frames(cfg_frames),
        .payload(payload), .pkt_valid(pkt_valid), .err_parity(err_parity),
        .err_stop(err_stop), .err_crc(err_crc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && pkt_valid) valid_cnt++;

    task automatic chk(input string req, input logic [MAXF*8-1:0] act,
                       input logic [MAXF*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[7] ^ pl[k][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic int eff_n(input logic [3:0] c);
        if (c == 0) return 1;
        if (c > MAXF) return MAXF;
        return int'(c);
    endfunction

    task automatic send_bit(input logic b);
        rx_line = b;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic send_idle(input int bits);
        for (int i = 0; i < bits; i++) send_bit(1'b1);
    endtask

    task automatic send_frame(input logic [7:0] v, input bit flip_par, input bit bad_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        send_bit((^v) ^ flip_par);
        send_bit(!bad_stop);
    endtask

    // send a packet; fault: 0 none, 1 parity flip on frame 2, 2 wrong check byte
    task automatic send_packet(input int n, input int fault, input int max_gap);
        for (int k = 0; k < n; k++) begin
            send_frame(pl[k], (fault == 1) && (k == 2), 1'b0);
            if (max_gap > 0) send_idle($urandom_range(max_gap, 0));
        end
        send_frame(ref_crc(n) ^ ((fault == 2) ? 8'h5A : 8'h00), 1'b0, 1'b0);
        send_idle(4);
    endtask

    function automatic logic [MAXF*8-1:0] pack_exp(input int n);
        logic [MAXF*8-1:0] v = '0;
        for (int k = 0; k < n; k++) v[k*8 +: 8] = pl[k];
        return v;
    endfunction

    task automatic good_packet(input string req, input int max_gap);
        int n;
        n = eff_n(cfg_frames);
        send_packet(n, 0, max_gap);
        exp_pl = pack_exp(n);
        exp_cnt++;
        chk({req, " payload"}, payload, exp_pl);
        chk({req, " valid count"}, MAXF*8'(valid_cnt), MAXF*8'(exp_cnt));
    endtask

    task automatic fill_random();
        for (int k = 0; k < MAXF; k++) pl[k] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 payload", payload, '0);
        chk("R9 flags", MAXF*8'({pkt_valid, err_parity, err_stop, err_crc}), '0);
        rst_n = 1'b1;
        send_idle(2);

        // R1 R3 R7: alternating 0xAA / 0x55, back to back frames
        for (int k = 0; k < MAXF; k++) pl[k] = (k % 2 == 0) ? 8'hAA : 8'h55;
        good_packet("R1 R3 R7 alternating", 0);

        // R8 R7: random packets with in-packet gaps under the timeout
        for (int p = 0; p < 8; p++) begin
            fill_random();
            good_packet("R8 R3 random gapped", 10);
        end

        // R2 R7: short packets, upper bytes zero
        cfg_frames = 4'd3;  fill_random(); good_packet("R2 R7 N=3", 2);
        cfg_frames = 4'd0;  fill_random(); good_packet("R2 N=0 as 1", 0);
        cfg_frames = 4'd15; fill_random(); good_packet("R2 N=15 as 14", 1);
        cfg_frames = 4'd14;

        // R4: parity fault, CRC still right
        chk("R4 no parity flag yet", MAXF*8'(err_parity), '0);
        fill_random();
        send_packet(MAXF, 1, 0);
        chk("R4 parity flag", MAXF*8'(err_parity), MAXF*8'(1));
        chk("R4 payload held", payload, exp_pl);
        chk("R4 no strobe", MAXF*8'(valid_cnt), MAXF*8'(exp_cnt));
        chk("R6 no crc flag on parity fault", MAXF*8'(err_crc), '0);
        fill_random(); good_packet("R4 recovery", 3);

        // R6: wrong check byte
        fill_random();
        send_packet(MAXF, 2, 0);
        chk("R6 crc flag", MAXF*8'(err_crc), MAXF*8'(1));
        chk("R6 payload held", payload, exp_pl);
        chk("R6 no strobe", MAXF*8'(valid_cnt), MAXF*8'(exp_cnt));

        // R8: partial packet, long idle, then a clean packet
        fill_random();
        for (int k = 0; k < 5; k++) send_frame(pl[k], 1'b0, 1'b0);
        send_idle(30);
        chk("R8 partial no strobe", MAXF*8'(valid_cnt), MAXF*8'(exp_cnt));
        fill_random(); good_packet("R8 resync", 0);

        // R5: low stop bit, abandoned packet, long idle
        chk("R5 no stop flag yet", MAXF*8'(err_stop), '0);
        fill_random();
        for (int k = 0; k < 3; k++) send_frame(pl[k], 1'b0, 1'b0);
        send_frame(8'h3C, 1'b0, 1'b1);
        send_idle(40);
        chk("R5 stop flag", MAXF*8'(err_stop), MAXF*8'(1));
        chk("R5 payload held", payload, exp_pl);
        fill_random(); good_packet("R5 recovery", 0);

        // R10: flags remain set
        chk("R10 sticky flags", MAXF*8'({err_parity, err_stop, err_crc}), MAXF*8'(3'b111));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule